// File: doc/BRIEF.md
# Multi-Lane Symbol Deskew Aligner

This block lines up the symbol streams of several serial lanes that share one symbol clock but reach the receiver with different delays. Each lane delivers one 8-bit symbol per cycle together with a control flag. During link training the far end sends the same ordered set on every lane in the same symbol time, so the comma that opens the set is a common timing marker. The aligner holds each lane's stream in a small FIFO starting at that lane's comma. A lane whose comma comes early waits in its FIFO longer than a lane whose comma comes late, and all lanes start to read together once the last comma has arrived.

While it searches, the block finds the first comma on any lane and then gives the other lanes a fixed window to show theirs. If the window runs out, it reports a skew error, empties every FIFO and searches again. Once locked, every FIFO writes and reads on each cycle, so the delay between lanes stays fixed. A realign request drops the lock and starts a new search. The aligned outputs feed the next receive stage, which decodes the ordered sets.

Top module: `lane_deskew_aligner`

## Requirements
- R1: After reset, `aligned` and `skew_err` are low and every output symbol and control flag is zero.
- R2: While `aligned` is low, all `lane_data_out` and `lane_k_out` bits are zero.
- R3: A comma is a symbol with its control flag set and data 0xBC. If the last lane's comma arrives no more than MAX_SKEW cycles after the first lane's comma, `aligned` rises in the cycle after the last comma is captured. In that first aligned cycle, every lane outputs the comma (flag 1, data 0xBC).
- R4: Once aligned, each lane outputs its input symbols in arrival order with no gap, repeat or loss. On every output cycle, all lanes show symbols that were sent in the same symbol time.
- R5: The extra delay of each lane equals the number of cycles by which its comma arrived before the last lane's comma, so earlier lanes are held longer.
- R6: If the first comma has been captured and some lane has shown none after MAX_SKEW more cycles, the partial search is discarded and the search starts again from the next comma. A skew of exactly MAX_SKEW still aligns.
- R7: Each skew failure raises `skew_err` for exactly one cycle, and `aligned` stays low.
- R8: A high `realign` in one cycle makes `aligned` low from the next cycle, empties all lanes and restarts the search.
- R9: While searching, symbols that arrive before a lane's comma are discarded. A symbol with data 0xBC and a clear control flag, or a control symbol with other data, is not a comma.
- R10: Once set, `aligned` stays high until `realign`. Commas that arrive while aligned pass through as ordinary symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| realign | input | 1 | Drop lock, empty the lanes and search again |
| lane_data_in | input | LANES*8 | Incoming symbol bytes, lane n at bits [8n+7:8n] |
| lane_k_in | input | LANES | Control flag of each incoming symbol |
| lane_data_out | output | LANES*8 | Deskewed symbol bytes, zero while not aligned |
| lane_k_out | output | LANES | Deskewed control flags, zero while not aligned |
| aligned | output | 1 | All lanes locked to a common marker |
| skew_err | output | 1 | One-cycle pulse when the skew window expires |

## Verification
The assertions assume that, after a comma, a lane that needs alignment keeps sending its stream one symbol per cycle. They also assume that the FIFO depth leaves room for the widest allowed skew plus one symbol. The FIFO depth is therefore never exceeded while the block searches or is locked. The stimulus builds each lane as one common sequence shifted by a chosen per-lane skew. The skews range from zero to exactly the limit, and in the error cases one lane is late by one symbol or sends no comma at all. Realign is raised only on cycle boundaries between bursts and once in the middle of a locked stream.

// File: rtl/lane_deskew_pkg.sv
`timescale 1ns/1ps
package lane_deskew_pkg;

    localparam int          SYM_BITS   = 8;
    localparam logic [7:0]  COMMA_BYTE = 8'hBC;

    typedef struct packed {
        logic                k;
        logic [SYM_BITS-1:0] data;
    } sym_t;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } dsk_state_e;

    function automatic logic is_comma(sym_t s);
        return s.k && (s.data == COMMA_BYTE);
    endfunction

endpackage

// File: rtl/deskew_lane_fifo.sv
`timescale 1ns/1ps
module deskew_lane_fifo
    import lane_deskew_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  sym_t          din,
    output sym_t          head,
    output logic [LW-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    sym_t          mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush && !rst) mem[wr_ptr] <= din;
    end

    assign head = mem[rd_ptr];

    // R5: the stored lead of an early lane must fit
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush) |-> (level < LW'(DEPTH)));

    // R4: a locked read always finds a symbol
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        (pop && !flush) |-> (level != '0));

endmodule

// File: rtl/deskew_ctrl.sv
`timescale 1ns/1ps
module deskew_ctrl
    import lane_deskew_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int MAX_SKEW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             realign,
    input  logic [LANES-1:0] comma_now,
    output logic             flush_all,
    output logic [LANES-1:0] push,
    output logic             pop_all,
    output logic             locked,
    output logic             skew_err
);
    localparam int            CW       = $clog2(MAX_SKEW + 1);
    localparam logic [CW-1:0] SKEW_LIM = CW'(MAX_SKEW);

    dsk_state_e       state;
    logic [LANES-1:0] seen;
    logic [LANES-1:0] seen_next;
    logic [CW-1:0]    wait_cnt;
    logic             any_seen;
    logic             all_next;
    logic             timeout;

    assign seen_next = seen | comma_now;
    assign any_seen  = |seen;
    assign all_next  = &seen_next;
    assign timeout   = (state == ST_SEARCH) && any_seen &&
                       (wait_cnt >= SKEW_LIM) && !all_next;

    assign locked    = (state == ST_LOCKED);
    assign pop_all   = locked;
    assign flush_all = realign || timeout;
    assign push      = locked ? '1 : seen_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_SEARCH;
            seen     <= '0;
            wait_cnt <= '0;
            skew_err <= 1'b0;
        end else begin
            skew_err <= timeout && !realign;
            if (realign) begin
                state    <= ST_SEARCH;
                seen     <= '0;
                wait_cnt <= '0;
            end else if (state == ST_SEARCH) begin
                if (timeout) begin
                    seen     <= '0;
                    wait_cnt <= '0;
                end else if (all_next) begin
                    state    <= ST_LOCKED;
                    seen     <= '0;
                    wait_cnt <= '0;
                end else if (|seen_next) begin
                    seen     <= seen_next;
                    wait_cnt <= any_seen ? wait_cnt + 1'b1 : CW'(1);
                end
            end
        end
    end

    // R6: the window counter never passes the skew budget
    p_window_bound_r6: assert property (@(posedge clk) disable iff (rst)
        wait_cnt <= SKEW_LIM);

    // R7: a skew failure is a single-cycle pulse
    p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        skew_err |=> !skew_err);

    // R6: a failed search never leaves the block locked
    p_err_unlocked_r6: assert property (@(posedge clk) disable iff (rst)
        skew_err |-> !locked);

    // R10: lock persists until realign
    p_lock_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (locked && !realign) |=> locked);

    // R8: realign drops lock and raises no error
    p_realign_r8: assert property (@(posedge clk) disable iff (rst)
        realign |=> (!locked && !skew_err));

endmodule

// File: rtl/lane_deskew_aligner.sv
`timescale 1ns/1ps
module lane_deskew_aligner #(
    parameter int LANES    = 4,
    parameter int DEPTH    = 8,
    parameter int MAX_SKEW = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               realign,
    input  logic [LANES*8-1:0] lane_data_in,
    input  logic [LANES-1:0]   lane_k_in,
    output logic [LANES*8-1:0] lane_data_out,
    output logic [LANES-1:0]   lane_k_out,
    output logic               aligned,
    output logic               skew_err
);
    import lane_deskew_pkg::*;

    localparam int LW = $clog2(DEPTH + 1);

    logic [LANES-1:0]    comma_now;
    logic [LANES-1:0]    push;
    logic                pop_all;
    logic                flush_all;
    logic                locked;
    logic [LANES*LW-1:0] levels_all;

    deskew_ctrl #(
        .LANES    (LANES),
        .MAX_SKEW (MAX_SKEW)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .realign   (realign),
        .comma_now (comma_now),
        .flush_all (flush_all),
        .push      (push),
        .pop_all   (pop_all),
        .locked    (locked),
        .skew_err  (skew_err)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sym_t          in_sym;
        sym_t          head;
        logic [LW-1:0] level;

        assign in_sym.k    = lane_k_in[g];
        assign in_sym.data = lane_data_in[g*8 +: 8];
        assign comma_now[g] = is_comma(in_sym);

        deskew_lane_fifo #(
            .DEPTH (DEPTH)
        ) fifo_i (
            .clk   (clk),
            .rst   (rst),
            .flush (flush_all),
            .push  (push[g]),
            .pop   (pop_all),
            .din   (in_sym),
            .head  (head),
            .level (level)
        );

        assign lane_data_out[g*8 +: 8] = locked ? head.data : 8'h00;
        assign lane_k_out[g]           = locked && head.k;
        assign levels_all[g*LW +: LW]  = level;
    end

    assign aligned = locked;

    // R3: the first locked cycle shows a comma on every lane
    p_first_comma_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned) |-> ((lane_k_out == '1) &&
                            (lane_data_out == {LANES{COMMA_BYTE}})));

    // R5: while locked the per-lane delays do not move
    p_fixed_offsets_r5: assert property (@(posedge clk) disable iff (rst)
        (aligned && !realign) |=> $stable(levels_all));

    // R2: nothing leaves the block before lock
    p_quiet_unlocked_r2: assert property (@(posedge clk) disable iff (rst)
        !aligned |-> ((lane_k_out == '0) && (lane_data_out == '0)));

endmodule

// File: tb/lane_deskew_aligner_tb_top.sv
`timescale 1ns/1ps
module lane_deskew_aligner_tb_top;

    localparam int LANES = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               realign = 1'b0;
    logic [LANES*8-1:0] lane_data_in = '0;
    logic [LANES-1:0]   lane_k_in = '0;
    logic [LANES*8-1:0] lane_data_out;
    logic [LANES-1:0]   lane_k_out;
    logic               aligned;
    logic               skew_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int skew [LANES];
    int blen;
    int bseed;

    logic [8:0] expq [$];

    always #2 clk = ~clk;

    lane_deskew_aligner #(.LANES(LANES), .DEPTH(8), .MAX_SKEW(5)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .realign       (realign),
        .lane_data_in  (lane_data_in),
        .lane_k_in     (lane_k_in),
        .lane_data_out (lane_data_out),
        .lane_k_out    (lane_k_out),
        .aligned       (aligned),
        .skew_err      (skew_err)
    );

    task automatic check_eq(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // common ordered-set stream: comma first, another comma at index 5
    function automatic logic [8:0] stream_sym(int j);
        if (j == 0 || j == 5) return {1'b1, 8'hBC};
        return {1'b0, 8'(bseed + j * 29)};
    endfunction

    function automatic logic [8:0] lane_sym(int ln, int t);
        int j = t - skew[ln];
        if (j < 0) return (ln == 0) ? {1'b0, 8'hBC} : {1'b1, 8'h1C};
        if (j >= blen) return {1'b0, 8'(j)};
        return stream_sym(j);
    endfunction

    task automatic drive(int t);
        for (int ln = 0; ln < LANES; ln++)
            {lane_k_in[ln], lane_data_in[ln*8 +: 8]} = lane_sym(ln, t);
    endtask

    // monitor: pops expected symbols while the design reports lock
    always @(negedge clk) begin
        if (!rst && aligned && expq.size() > 0) begin
            logic [8:0] e;
            e = expq.pop_front();
            for (int ln = 0; ln < LANES; ln++)
                check_eq("R4 R5", $sformatf("lane %0d symbol", ln),
                         {lane_k_out[ln], lane_data_out[ln*8 +: 8]}, e);
        end
    end

    task automatic run_ok(int s0, int s1, int s2, int s3, int len, int seed, bit do_realign);
        int d;
        skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
        blen = len; bseed = seed;
        d = s0;
        for (int ln = 1; ln < LANES; ln++) if (skew[ln] > d) d = skew[ln];
        if (do_realign) begin
            @(posedge clk); #1;
            realign = 1'b1;
            drive(-1);
        end
        for (int t = 0; t <= d + len + 1; t++) begin
            @(posedge clk); #1;
            realign = 1'b0;
            if (t == 0) for (int j = 0; j < len; j++) expq.push_back(stream_sym(j));
            drive(t);
            #2;
            if (t == d) begin
                check_eq("R3", "aligned before last comma", aligned, 0);
                check_eq("R2", "data while searching", lane_data_out, 0);
            end
            if (t == d + 1) begin
                check_eq("R3", "aligned after last comma", aligned, 1);
                check_eq("R3 R9", "first locked flags", lane_k_out, 4'hF);
                check_eq("R3 R9", "first locked data", lane_data_out, 32'hBCBCBCBC);
            end
        end
        check_eq("R10", "still aligned after mid-stream comma", aligned, 1);
        check_eq("R4", "expected symbols left undelivered", expq.size(), 0);
        expq.delete();
    endtask

    task automatic run_err(int s0, int s1, int s2, int s3, int len, int second_t);
        skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
        blen = len; bseed = 11;
        @(posedge clk); #1;
        realign = 1'b1;
        drive(-1);
        for (int t = 0; t <= 12; t++) begin
            @(posedge clk); #1;
            realign = 1'b0;
            drive(t);
            #2;
            check_eq("R7", $sformatf("aligned during failed search t=%0d", t), aligned, 0);
            if (t == 6) check_eq("R6 R7", "skew error at window end", skew_err, 1);
            if (t == 7) check_eq("R7", "skew error pulse width", skew_err, 0);
            if (second_t != 0 && t == second_t)
                check_eq("R6", "restarted search also expires", skew_err, 1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        check_eq("R1", "aligned after reset", aligned, 0);
        check_eq("R1", "skew_err after reset", skew_err, 0);
        check_eq("R1", "data after reset", lane_data_out, 0);
        check_eq("R1", "flags after reset", lane_k_out, 0);

        run_ok(0, 2, 1, 3, 20, 7, 1'b1);
        run_ok(5, 0, 3, 5, 16, 91, 1'b1);
        run_ok(0, 0, 0, 0, 10, 3, 1'b1);

        run_err(0, 0, 0, 99, 1, 0);
        run_err(0, 6, 2, 1, 12, 12);
        run_ok(4, 1, 0, 2, 12, 55, 1'b0);

        // R8: realign in the middle of a locked stream
        @(posedge clk); #1;
        realign = 1'b1;
        #2;
        check_eq("R8", "aligned in realign cycle", aligned, 1);
        @(posedge clk); #1;
        realign = 1'b0;
        #2;
        check_eq("R8", "aligned after realign", aligned, 0);
        check_eq("R8", "data after realign", lane_data_out, 0);
        check_eq("R8", "no error on realign", skew_err, 0);
        repeat (3) @(posedge clk);
        #3;
        check_eq("R8", "stays searching without commas", aligned, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule